// File: doc/BRIEF.md
# Per-Channel Amplifier Bias Calibration Sequencer

This controller picks a bias-current code for each amplifier in a recording array. Every amplifier does not get the same worst-case bias. One low-noise measurement path is shared by the whole array. The controller steers that path to one channel at a time through an analog multiplexer select. It powers the path only while a calibration scan runs. The shared amplifier, the envelope detector and the current DACs sit outside this block. They appear here only as digitized inputs and code outputs.

For each channel, the controller waits a programmable settling interval after the multiplexer moves. It then takes one noise-envelope sample and one peak-spike sample. It turns them into a DAC code and writes that code into a per-channel bank. A quiet channel gets a high bias code and a noisy channel gets a low one. A channel whose spikes stand well above its noise floor is given a programmable low-power code instead. The bank drives every DAC in parallel and keeps its contents until the next scan. A scan begins on a start pulse or when an idle-period timer expires. The settling time, spike factor, low-power code and code limits are captured at the start of each scan.

Top module: `bias_cal_seq`

## Requirements
- R1: After reset, `busy_o`, `meas_pwr_o` and `done_o` are 0. Every bank entry, on `rd_code_o` and on `bias_flat_o`, holds the all-ones code (63 for 6-bit codes).
- R2: A start pulse while idle raises `busy_o` and `meas_pwr_o` on the next cycle. Both stay high for exactly N_CH×(settle+1) cycles. In the first cycle after that, both are low and `done_o` is high for that single cycle.
- R3: During a scan, `mux_sel_o` begins at 0 and moves up by one to N_CH−1. Each channel is held for settle+1 cycles. The samples are taken in the last of those cycles, after the select has been steady for `settle` cycles.
- R4: The base code is min(63, floor(512/(env+1))). This rises as the envelope falls.
- R5: The base code is raised to `code_floor_i` if it is below it, then lowered to `code_ceil_i` if it is above it.
- R6: When the spike check is enabled and peak > env×`spike_mult_i`, the stored code is `low_code_i`, bypassing R4 and R5.
- R7: When the spike check is disabled, or when peak equals env×`spike_mult_i` exactly, no override takes place.
- R8: The bank holds its codes unchanged between scans whatever the inputs do. Channel c is on `bias_flat_o[c*6 +: 6]`, and is also on `rd_code_o` one combinational step after `rd_addr_i` = c.
- R9: A start pulse during a scan is ignored. Configuration changes made during a scan have no effect on that scan's timing or codes.
- R10: With `period_i` = P ≠ 0, a new scan begins after P idle cycles (counting the `done_o` cycle). With `period_i` = 0, no scan begins without a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-scan pulse |
| period_i | input | 16 | Idle cycles between automatic scans; 0 disables |
| settle_i | input | 8 | Settling cycles after each select change |
| spike_mult_i | input | 4 | Spike-to-envelope override factor |
| spike_chk_i | input | 1 | Enables the spike override |
| low_code_i | input | 6 | Code forced on spike override |
| code_floor_i | input | 6 | Lowest allowed mapped code |
| code_ceil_i | input | 6 | Highest allowed mapped code |
| env_i | input | 8 | Digitized noise envelope of the selected channel |
| peak_i | input | 8 | Digitized peak spike amplitude of the selected channel |
| meas_pwr_o | output | 1 | Power enable of the shared measurement path |
| mux_sel_o | output | 6 | Analog multiplexer channel select |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| rd_addr_i | input | 6 | Bank read address |
| rd_code_o | output | 6 | Bank read data |
| bias_flat_o | output | 384 | All channel codes, channel c at bits c*6 +: 6 |

## Verification
The hardest case to reach is a sample taken before the select has settled, because a correct design never shows it at the ports. The bench models the analog path: it returns a false envelope of zero until the select has been steady for the settling time. A sample taken one cycle early would therefore store the saturated code. The auto-period gap and a configuration change in mid-scan are timing-sensitive. The bench reaches them by arming the period timer in an idle window, and by changing settle, ceiling and spike enable while pulsing start inside a running scan.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    localparam int ENV_W   = 8;
    localparam int CODE_W  = 6;
    localparam int SET_W   = 8;
    localparam int PER_W   = 16;
    localparam int MUL_W   = 4;
    localparam int RECIP_K = 512;
    localparam int PROD_W  = ENV_W + MUL_W;

    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_TOP = '1;

    typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

    typedef struct packed {
        logic [SET_W-1:0] settle;
        logic [MUL_W-1:0] mult;
        code_t            lo_pwr;
        code_t            floor_c;
        code_t            ceil_c;
        logic             spk_chk;
    } cfg_t;

    typedef struct packed {
        logic [ENV_W-1:0] env;
        logic [ENV_W-1:0] peak;
    } meas_t;

    function automatic code_t recip_code(input logic [ENV_W-1:0] env);
        int q;
        q = RECIP_K / (int'(env) + 1);
        if (q > int'(CODE_TOP)) return CODE_TOP;
        return code_t'(q);
    endfunction
endpackage

// File: rtl/bcs_trigger.sv
module bcs_trigger
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic             start_i,
    input  logic [PER_W-1:0] period_i,
    output logic             fire_o
);
    logic [PER_W-1:0] tmr;
    logic             per_on;
    logic             per_hit;

    assign per_on  = (period_i != '0);
    assign per_hit = per_on && (tmr >= period_i - PER_W'(1));
    assign fire_o  = !busy_i && (start_i || per_hit);

    always_ff @(posedge clk) begin
        if (rst || busy_i || !per_on) tmr <= '0;
        else if (tmr != '1)          tmr <= tmr + PER_W'(1);
    end

    // R10: timer never runs while a scan is active
    p_timer_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(busy_i) |-> tmr == '0);
endmodule

// File: rtl/bcs_scan.sv
module bcs_scan
    import bcs_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int CH_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire_i,
    input  cfg_t            cfg_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [CH_W-1:0] sel_o,
    output logic            sample_o,
    output cfg_t            cfg_o
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    scan_st_e         st;
    logic [CH_W-1:0]  ch;
    logic [SET_W-1:0] cnt;
    cfg_t             cfg_q;
    logic             done_q;
    logic             at_end;

    assign busy_o   = (st == ST_SCAN);
    assign sample_o = busy_o && (cnt == cfg_q.settle);
    assign at_end   = sample_o && (ch == LAST_CH);
    assign sel_o    = ch;
    assign done_o   = done_q;
    assign cfg_o    = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ch     <= '0;
            cnt    <= '0;
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (fire_i) begin
                        st    <= ST_SCAN;
                        cfg_q <= cfg_i;
                        ch    <= '0;
                        cnt   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (sample_o) begin
                        cnt <= '0;
                        if (at_end) begin
                            st     <= ST_IDLE;
                            ch     <= '0;
                            done_q <= 1'b1;
                        end else begin
                            ch <= ch + CH_W'(1);
                        end
                    end else begin
                        cnt <= cnt + SET_W'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: done only right after a scan ends
    p_done_after_scan_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_o && $past(busy_o)));
    // R2: done lasts a single cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R3: select only steps upward by one inside a scan
    p_mux_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && sel_o != $past(sel_o)) |-> sel_o == CH_W'($past(sel_o) + CH_W'(1)));
    // R9: a scan cannot end before its last sample
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !at_end) |=> busy_o);
    // R9: captured configuration is steady for the whole scan
    p_cfg_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(cfg_q));
endmodule

// File: rtl/bcs_map.sv
module bcs_map
    import bcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  meas_t meas_i,
    input  cfg_t  cfg_i,
    output code_t code_o
);
    code_t             base;
    code_t             clamped;
    logic [PROD_W-1:0] thresh;
    logic              ovr;

    always_comb begin
        base    = recip_code(meas_i.env);
        clamped = base;
        if (clamped < cfg_i.floor_c) clamped = cfg_i.floor_c;
        if (clamped > cfg_i.ceil_c)  clamped = cfg_i.ceil_c;
        thresh  = PROD_W'(meas_i.env) * PROD_W'(cfg_i.mult);
        ovr     = cfg_i.spk_chk && (PROD_W'(meas_i.peak) > thresh);
        code_o  = ovr ? cfg_i.lo_pwr : clamped;
    end

    // R5: mapped code respects the limits when they are ordered
    p_code_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (!ovr && cfg_i.floor_c <= cfg_i.ceil_c) |-> (code_o >= cfg_i.floor_c && code_o <= cfg_i.ceil_c));
endmodule

// File: rtl/bcs_bank.sv
module bcs_bank
    import bcs_pkg::*;
#(
    parameter int N_CH = 64,
    parameter int CH_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [CH_W-1:0]          wr_ch_i,
    input  code_t                    wr_code_i,
    input  logic [CH_W-1:0]          rd_addr_i,
    output code_t                    rd_code_o,
    output logic [N_CH*CODE_W-1:0]   flat_o
);
    code_t regs [N_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) regs[i] <= CODE_TOP;
        end else if (we_i) begin
            regs[wr_ch_i] <= wr_code_i;
        end
    end

    assign rd_code_o = (int'(rd_addr_i) < N_CH) ? regs[rd_addr_i] : '0;

    for (genvar g = 0; g < N_CH; g++) begin : g_flat
        assign flat_o[g*CODE_W +: CODE_W] = regs[g];
    end

    // R8: codes are held when nothing is written
    p_bank_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(flat_o));
endmodule

// File: rtl/bias_cal_seq.sv
module bias_cal_seq
    import bcs_pkg::*;
#(
    parameter int N_CH = 64,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int FLAT_W = N_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [SET_W-1:0]  settle_i,
    input  logic [MUL_W-1:0]  spike_mult_i,
    input  logic              spike_chk_i,
    input  logic [CODE_W-1:0] low_code_i,
    input  logic [CODE_W-1:0] code_floor_i,
    input  logic [CODE_W-1:0] code_ceil_i,
    input  logic [ENV_W-1:0]  env_i,
    input  logic [ENV_W-1:0]  peak_i,
    output logic              meas_pwr_o,
    output logic [CH_W-1:0]   mux_sel_o,
    output logic              busy_o,
    output logic              done_o,
    input  logic [CH_W-1:0]   rd_addr_i,
    output logic [CODE_W-1:0] rd_code_o,
    output logic [FLAT_W-1:0] bias_flat_o
);
    cfg_t  cfg_in;
    cfg_t  cfg_run;
    meas_t meas;
    code_t new_code;
    logic  fire;
    logic  busy;
    logic  sample;

    assign cfg_in = '{settle: settle_i, mult: spike_mult_i, lo_pwr: low_code_i,
                      floor_c: code_floor_i, ceil_c: code_ceil_i, spk_chk: spike_chk_i};
    assign meas   = '{env: env_i, peak: peak_i};

    bcs_trigger u_trig (
        .clk(clk), .rst(rst), .busy_i(busy), .start_i(start_i),
        .period_i(period_i), .fire_o(fire)
    );

    bcs_scan #(.N_CH(N_CH), .CH_W(CH_W)) u_scan (
        .clk(clk), .rst(rst), .fire_i(fire), .cfg_i(cfg_in),
        .busy_o(busy), .done_o(done_o), .sel_o(mux_sel_o),
        .sample_o(sample), .cfg_o(cfg_run)
    );

    bcs_map u_map (
        .clk(clk), .rst(rst), .meas_i(meas), .cfg_i(cfg_run), .code_o(new_code)
    );

    bcs_bank #(.N_CH(N_CH), .CH_W(CH_W)) u_bank (
        .clk(clk), .rst(rst), .we_i(sample), .wr_ch_i(mux_sel_o),
        .wr_code_i(new_code), .rd_addr_i(rd_addr_i), .rd_code_o(rd_code_o),
        .flat_o(bias_flat_o)
    );

    assign busy_o     = busy;
    assign meas_pwr_o = busy;
endmodule

// File: tb/tb_bias_cal_seq.sv
module tb_bias_cal_seq;
    localparam int N = 64;
    localparam int CW = 6;

    logic        clk = 0;
    logic        rst = 1;
    logic        start_i = 0;
    logic [15:0] period_i = 0;
    logic [7:0]  settle_i = 0;
    logic [3:0]  spike_mult_i = 0;
    logic        spike_chk_i = 0;
    logic [5:0]  low_code_i = 0;
    logic [5:0]  code_floor_i = 0;
    logic [5:0]  code_ceil_i = 63;
    logic [7:0]  env_i = 0;
    logic [7:0]  peak_i = 0;
    logic        meas_pwr_o;
    logic [5:0]  mux_sel_o;
    logic        busy_o;
    logic        done_o;
    logic [5:0]  rd_addr_i = 0;
    logic [5:0]  rd_code_o;
    logic [N*CW-1:0] bias_flat_o;

    bias_cal_seq #(.N_CH(N)) dut (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int exp_q[$];
    int env_arr[N];
    int peak_arr[N];
    int cur_settle = 0;
    int done_cnt = 0;
    int age = 0;
    logic last_busy = 0;
    int last_sel = 0;
    int run_len = 0;
    logic m_prev_busy = 0;
    int m_prev_sel = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_code(int env, int pk, int en, int mult, int lo, int fl, int ce);
        int raw;
        if (en != 0 && pk > env * mult) return lo;
        raw = 512 / (env + 1);
        if (raw > 63) raw = 63;
        if (raw < fl) raw = fl;
        if (raw > ce) raw = ce;
        return raw;
    endfunction

    // analog path model: envelope is wrong (0) until select has settled
    always @(negedge clk) begin
        if (busy_o && (!last_busy || int'(mux_sel_o) != last_sel)) age = 0;
        else age = age + 1;
        last_busy = busy_o;
        last_sel  = int'(mux_sel_o);
        if (age >= cur_settle) begin
            env_i  = 8'(env_arr[mux_sel_o]);
            peak_i = 8'(peak_arr[mux_sel_o]);
        end else begin
            env_i  = 8'd0;
            peak_i = 8'd0;
        end
    end

    // monitor: select ordering (R3) and scoreboard of codes on done
    always @(negedge clk) begin
        if (!rst) begin
            if (busy_o && !m_prev_busy) begin
                chk("R3 first select", int'(mux_sel_o), 0);
                run_len = 1;
            end else if (busy_o && m_prev_busy) begin
                if (int'(mux_sel_o) != m_prev_sel) begin
                    chk("R3 select step", int'(mux_sel_o), m_prev_sel + 1);
                    chk("R3 hold length", run_len, cur_settle + 1);
                    run_len = 1;
                end else run_len++;
            end
            if (done_o) begin
                done_cnt++;
                for (int c = 0; c < N; c++) begin
                    if (exp_q.size() == 0) begin
                        chk("R4 scoreboard empty", 1, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk($sformatf("R4/R5/R6/R7 code ch%0d", c), int'(bias_flat_o[c*CW +: CW]), e);
                    end
                end
            end
        end
        m_prev_busy = busy_o;
        m_prev_sel  = int'(mux_sel_o);
    end

    task automatic push_expected();
        for (int c = 0; c < N; c++)
            exp_q.push_back(exp_code(env_arr[c], peak_arr[c], int'(spike_chk_i), int'(spike_mult_i),
                                     int'(low_code_i), int'(code_floor_i), int'(code_ceil_i)));
    endtask

    task automatic run_pass(input bit disturb);
        int len;
        int d0;
        cur_settle = int'(settle_i);
        push_expected();
        d0 = done_cnt;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R2 busy after start", int'(busy_o), 1);
        chk("R2 power after start", int'(meas_pwr_o), 1);
        len = 1;
        while (busy_o && len < 100000) begin
            @(negedge clk);
            if (disturb && len == 20) begin
                start_i = 1;
                code_ceil_i = 20;
                spike_chk_i = 1;
                settle_i = 0;
            end
            if (disturb && len == 21) start_i = 0;
            if (busy_o) len++;
        end
        chk("R2/R9 scan length", len, N * (cur_settle + 1));
        chk("R2 done at end", int'(done_o), 1);
        chk("R2 power off at end", int'(meas_pwr_o), 0);
        @(negedge clk);
        chk("R2/R9 single done", done_cnt - d0, 1);
        chk("R2 done one cycle", int'(done_o), 0);
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            env_arr[c]  = (c * 29 + 3) % 256;
            peak_arr[c] = (c * 53 + 11) % 256;
        end
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 power", int'(meas_pwr_o), 0);
        chk("R1 done", int'(done_o), 0);
        rd_addr_i = 0; #1;
        chk("R1 read ch0", int'(rd_code_o), 63);
        rd_addr_i = 63; #1;
        chk("R1 read ch63", int'(rd_code_o), 63);
        chk("R1 flat all ones", int'(&bias_flat_o), 1);

        // pass 1: plain reciprocal map (R4)
        settle_i = 3; spike_mult_i = 3; low_code_i = 5;
        code_floor_i = 0; code_ceil_i = 63; spike_chk_i = 0;
        @(negedge clk);
        run_pass(0);
        // R8 read port
        rd_addr_i = 17; #1;
        chk("R8 read ch17", int'(rd_code_o), exp_code(env_arr[17], 0, 0, 0, 0, 0, 63));
        rd_addr_i = 63; #1;
        chk("R8 read ch63", int'(rd_code_o), exp_code(env_arr[63], 0, 0, 0, 0, 0, 63));

        // pass 2: clamps (R5), override (R6), equality boundary (R7)
        env_arr[7] = 40; peak_arr[7] = 120;
        env_arr[8] = 40; peak_arr[8] = 121;
        env_arr[9] = 0;  peak_arr[9] = 1;
        spike_chk_i = 1; code_floor_i = 10; code_ceil_i = 50;
        @(negedge clk);
        run_pass(0);
        chk("R7 equal no override", int'(bias_flat_o[7*CW +: CW]), 12);
        chk("R6 override ch8", int'(bias_flat_o[8*CW +: CW]), 5);

        // pass 3: mid-scan start and config change ignored (R9)
        spike_chk_i = 0; code_floor_i = 0; code_ceil_i = 63; settle_i = 2;
        @(negedge clk);
        run_pass(1);

        // R8 hold between scans
        begin
            logic [N*CW-1:0] snap;
            bit moved;
            snap = bias_flat_o;
            moved = 0;
            for (int c = 0; c < N; c++) begin
                env_arr[c] = 200 + (c % 50);
                peak_arr[c] = c;
            end
            code_ceil_i = 63; spike_chk_i = 0; settle_i = 0;
            repeat (200) begin
                @(negedge clk);
                if (bias_flat_o != snap || busy_o) moved = 1;
            end
            chk("R8 hold while idle", int'(moved), 0);
        end

        // pass 4: zero settle boundary
        run_pass(0);

        // R10 periodic scans
        begin
            int idle;
            int w;
            settle_i = 1; cur_settle = 1;
            push_expected();
            push_expected();
            period_i = 20;
            w = 0;
            while (!busy_o && w < 2000) begin @(negedge clk); w++; end
            chk("R10 auto scan started", int'(busy_o), 1);
            while (busy_o) @(negedge clk);
            chk("R10 done first auto", int'(done_o), 1);
            idle = 1;
            @(negedge clk);
            while (!busy_o && idle < 2000) begin idle++; @(negedge clk); end
            chk("R10 idle gap", idle, 20);
            period_i = 0;
            while (busy_o) @(negedge clk);
            w = 0;
            repeat (300) begin @(negedge clk); if (busy_o) w++; end
            chk("R10 period zero quiet", w, 0);
            chk("R10 queue drained", exp_q.size(), 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule